// File: doc/BRIEF.md
# Puncture and Depuncture Unit

This block adapts the rate of a convolutionally coded stream by deleting or restoring symbols under control of a fixed keep pattern. Each word is treated as `FULL_W` symbols of `SYM_W` bits, with symbol j on bits `j*SYM_W+SYM_W-1 .. j*SYM_W`. The pattern has one bit per symbol position: a 1 marks a position that carries data and a 0 marks a position that is dropped (puncture) or filled (depuncture).

A mode parameter picks the direction. In puncture mode a full-width word enters and only the marked symbols leave, packed into a narrower word. In depuncture mode a narrow word enters and is spread back over the marked positions, with a filler symbol (for example a soft-decision erasure value) placed at every unmarked position. That rebuilt word goes to a decoder.

The mapping is combinational and feeds a single output register. The valid flag travels with the data through the same register.

Top module: `pra_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `out_data` becomes all zeros, whatever the inputs are.
- R2: `out_valid` after each edge equals `in_valid` before that edge. Data sampled with `in_valid` low still appears on `out_data` one cycle later, marked invalid.
- R3: In puncture mode, output symbol k is the input symbol at the k-th position whose pattern bit is 1, counting up from position 0. Output symbol 0 comes from the lowest kept position.
- R4: In puncture mode the output holds exactly as many symbols as the pattern has ones. Input symbols at positions whose pattern bit is 0 have no effect on `out_data`.
- R5: In depuncture mode, input symbol k is placed at the k-th position whose pattern bit is 1, counting up from position 0.
- R6: In depuncture mode, every position whose pattern bit is 0 carries the multi-bit `FILL` symbol, whatever the input data is.
- R7: With an all-ones pattern the block acts as a plain one-cycle register. A stream of back-to-back words comes out unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | IN_W (24 by default) | Full word in puncture mode, packed word in depuncture mode |
| out_valid | output | 1 | Registered qualifier, one cycle after `in_valid` |
| out_data | output | OUT_W (15 by default) | Registered result: packed word in puncture mode, rebuilt word in depuncture mode |

## Verification
The bench uses a pattern whose kept positions are not contiguous and start above position 0. A design that packed kept symbols from the top, or that counted ranks from the wrong end, shows swapped symbols on the output. The bench flips only the dropped symbols to catch a design that lets them leak into the packed word. It drives the depuncturer with all-zero and all-one data and uses a filler that is neither of those, so a filler tied to a constant or taken from a neighbouring symbol is exposed. An all-ones pattern streamed every cycle with alternating valid catches an extra or missing pipeline stage, and an invalid word that does not pass through is caught as well.

// File: rtl/pra_pkg.sv
package pra_pkg;

  typedef enum logic {
    PRA_PUNCTURE   = 1'b0,
    PRA_DEPUNCTURE = 1'b1
  } pra_mode_e;

  // Number of set bits among the lowest n bits of a pattern.
  function automatic int pra_ones(input logic [63:0] pat, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pat[i]) c++;
    end
    return c;
  endfunction

  // Rank of a kept position: how many kept positions lie below it.
  function automatic int pra_rank(input logic [63:0] pat, input int pos);
    return pra_ones(pat, pos);
  endfunction

endpackage

// File: rtl/pra_drop_core.sv
module pra_drop_core #(
  parameter int FULL_W = 8,
  parameter int SYM_W = 3,
  parameter logic [FULL_W-1:0] PATTERN = 8'b1011_0110,
  localparam int KEPT = pra_pkg::pra_ones(64'(PATTERN), FULL_W)
) (
  input  logic [FULL_W*SYM_W-1:0] wide_i,
  output logic [KEPT*SYM_W-1:0]   narrow_o
);

  always_comb begin
    int k;
    k = 0;
    narrow_o = '0;
    for (int i = 0; i < FULL_W; i++) begin
      if (PATTERN[i]) begin
        narrow_o[k*SYM_W +: SYM_W] = wide_i[i*SYM_W +: SYM_W];
        k++;
      end
    end
  end

endmodule

// File: rtl/pra_fill_core.sv
module pra_fill_core #(
  parameter int FULL_W = 8,
  parameter int SYM_W = 3,
  parameter logic [FULL_W-1:0] PATTERN = 8'b1011_0110,
  parameter logic [SYM_W-1:0] FILL = 3'b100,
  localparam int KEPT = pra_pkg::pra_ones(64'(PATTERN), FULL_W)
) (
  input  logic [KEPT*SYM_W-1:0]   narrow_i,
  output logic [FULL_W*SYM_W-1:0] wide_o
);

  always_comb begin
    int k;
    k = 0;
    wide_o = '0;
    for (int i = 0; i < FULL_W; i++) begin
      if (PATTERN[i]) begin
        wide_o[i*SYM_W +: SYM_W] = narrow_i[k*SYM_W +: SYM_W];
        k++;
      end else begin
        wide_o[i*SYM_W +: SYM_W] = FILL;
      end
    end
  end

endmodule

// File: rtl/pra_out_reg.sv
module pra_out_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_d,
  input  logic [W-1:0] dat_d,
  output logic         vld_q,
  output logic [W-1:0] dat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

endmodule

// File: rtl/pra_unit.sv
module pra_unit #(
  parameter int FULL_W = 8,
  parameter int SYM_W = 3,
  parameter logic [FULL_W-1:0] PATTERN = 8'b1011_0110,
  parameter pra_pkg::pra_mode_e MODE = pra_pkg::PRA_PUNCTURE,
  parameter logic [SYM_W-1:0] FILL = 3'b100,
  localparam int KEPT = pra_pkg::pra_ones(64'(PATTERN), FULL_W),
  localparam int WIDE_W = FULL_W * SYM_W,
  localparam int NARROW_W = KEPT * SYM_W,
  localparam int IN_W = (MODE == pra_pkg::PRA_PUNCTURE) ? WIDE_W : NARROW_W,
  localparam int OUT_W = (MODE == pra_pkg::PRA_PUNCTURE) ? NARROW_W : WIDE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  logic [OUT_W-1:0] mapped;

  generate
    if (MODE == pra_pkg::PRA_PUNCTURE) begin : g_drop
      pra_drop_core #(
        .FULL_W (FULL_W),
        .SYM_W  (SYM_W),
        .PATTERN(PATTERN)
      ) u_core (
        .wide_i  (in_data),
        .narrow_o(mapped)
      );
    end else begin : g_fill
      pra_fill_core #(
        .FULL_W (FULL_W),
        .SYM_W  (SYM_W),
        .PATTERN(PATTERN),
        .FILL   (FILL)
      ) u_core (
        .narrow_i(in_data),
        .wide_o  (mapped)
      );
    end
  endgenerate

  pra_out_reg #(
    .W(OUT_W)
  ) u_reg (
    .clk  (clk),
    .rst  (rst),
    .vld_d(in_valid),
    .dat_d(mapped),
    .vld_q(out_valid),
    .dat_q(out_data)
  );

endmodule

// File: rtl/pra_unit_chk.sv
module pra_unit_chk #(
  parameter int FULL_W = 8,
  parameter int SYM_W = 3,
  parameter logic [FULL_W-1:0] PATTERN = 8'b1011_0110,
  parameter pra_pkg::pra_mode_e MODE = pra_pkg::PRA_PUNCTURE,
  parameter logic [SYM_W-1:0] FILL = 3'b100,
  localparam int KEPT = pra_pkg::pra_ones(64'(PATTERN), FULL_W),
  localparam int WIDE_W = FULL_W * SYM_W,
  localparam int NARROW_W = KEPT * SYM_W,
  localparam int IN_W = (MODE == pra_pkg::PRA_PUNCTURE) ? WIDE_W : NARROW_W,
  localparam int OUT_W = (MODE == pra_pkg::PRA_PUNCTURE) ? NARROW_W : WIDE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R2
  a_r2_valid_passes: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_invalid_passes: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  generate
    for (genvar i = 0; i < FULL_W; i++) begin : g_pos
      localparam int RK = pra_pkg::pra_rank(64'(PATTERN), i);
      if (MODE == pra_pkg::PRA_PUNCTURE) begin : g_p
        if (PATTERN[i]) begin : g_k
          // R3 and R7: kept symbol lands at its rank
          a_r3_kept_order: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_data[RK*SYM_W +: SYM_W] == $past(in_data[i*SYM_W +: SYM_W]));
        end
      end else begin : g_d
        if (PATTERN[i]) begin : g_k
          a_r5_spread_order: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_data[i*SYM_W +: SYM_W] == $past(in_data[RK*SYM_W +: SYM_W]));
        end else begin : g_f
          a_r6_filler_symbol: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_data[i*SYM_W +: SYM_W] == FILL);
        end
      end
    end
  endgenerate

endmodule

bind pra_unit pra_unit_chk #(
  .FULL_W (FULL_W),
  .SYM_W  (SYM_W),
  .PATTERN(PATTERN),
  .MODE   (MODE),
  .FILL   (FILL)
) u_chk (.*);

// File: tb/tb_pra_unit.sv
module tb_pra_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PAT = 8'b1011_0110;
  localparam logic [2:0] FIL = 3'b100;
  localparam logic [23:0] DROP_MASK = 24'h1C0E07; // symbols 0, 3 and 6

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic        p_vld = 1'b0;
  logic [23:0] p_in  = '0;
  logic        p_ovld;
  logic [14:0] p_out;

  logic        d_vld = 1'b0;
  logic [14:0] d_in  = '0;
  logic        d_ovld;
  logic [23:0] d_out;

  logic        r_vld = 1'b0;
  logic [7:0]  r_in  = '0;
  logic        r_ovld;
  logic [7:0]  r_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pra_unit #(
    .FULL_W(8), .SYM_W(3), .PATTERN(PAT), .MODE(pra_pkg::PRA_PUNCTURE), .FILL(FIL)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(p_vld), .in_data(p_in),
    .out_valid(p_ovld), .out_data(p_out)
  );

  pra_unit #(
    .FULL_W(8), .SYM_W(3), .PATTERN(PAT), .MODE(pra_pkg::PRA_DEPUNCTURE), .FILL(FIL)
  ) dut_dep (
    .clk(clk), .rst(rst), .in_valid(d_vld), .in_data(d_in),
    .out_valid(d_ovld), .out_data(d_out)
  );

  pra_unit #(
    .FULL_W(4), .SYM_W(2), .PATTERN(4'hF), .MODE(pra_pkg::PRA_PUNCTURE), .FILL(2'b00)
  ) dut_reg (
    .clk(clk), .rst(rst), .in_valid(r_vld), .in_data(r_in),
    .out_valid(r_ovld), .out_data(r_out)
  );

  // Expected packing: kept positions 7,5,4,2,1 from MSB to LSB
  function automatic logic [14:0] exp_drop(input logic [23:0] w);
    return {w[23:21], w[17:15], w[14:12], w[8:6], w[5:3]};
  endfunction

  // Expected spreading: positions 7..0 = s4, F, s3, s2, F, s1, s0, F
  function automatic logic [23:0] exp_fill(input logic [14:0] n);
    return {n[14:12], FIL, n[11:9], n[8:6], FIL, n[5:3], n[2:0], FIL};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    p_vld = 1'b1; p_in = '1;
    d_vld = 1'b1; d_in = '1;
    r_vld = 1'b1; r_in = '1;
    repeat (3) @(negedge clk);
    chk("R1 p valid", 32'(p_ovld), 32'd0);
    chk("R1 p data",  32'(p_out),  32'd0);
    chk("R1 d valid", 32'(d_ovld), 32'd0);
    chk("R1 d data",  32'(d_out),  32'd0);
    chk("R1 r data",  32'(r_out),  32'd0);
    p_vld = 1'b0; d_vld = 1'b0; r_vld = 1'b0;
    p_in = '0; d_in = '0; r_in = '0;
    rst = 1'b0;
  endtask

  task automatic drive_p(input logic v, input logic [23:0] w);
    @(negedge clk);
    p_vld = v; p_in = w;
    @(negedge clk);
  endtask

  task automatic drive_d(input logic v, input logic [14:0] n);
    @(negedge clk);
    d_vld = v; d_in = n;
    @(negedge clk);
  endtask

  task automatic t_puncture();
    logic [23:0] vec [4] = '{24'h000000, 24'hFFFFFF, 24'hFAC688, 24'h123456};
    for (int i = 0; i < 4; i++) begin
      drive_p(1'b1, vec[i]);
      chk("R3 punct data", 32'(p_out), 32'(exp_drop(vec[i])));
      chk("R2 punct valid", 32'(p_ovld), 32'd1);
    end
  endtask

  task automatic t_drop_ignored();
    logic [23:0] base;
    logic [14:0] first;
    base = 24'hA5C3E1;
    drive_p(1'b1, base);
    first = p_out;
    chk("R4 punct base", 32'(first), 32'(exp_drop(base)));
    drive_p(1'b1, base ^ DROP_MASK);
    chk("R4 dropped symbols ignored", 32'(p_out), 32'(first));
    drive_p(1'b1, base | DROP_MASK);
    chk("R4 dropped symbols set", 32'(p_out), 32'(first));
  endtask

  task automatic t_invalid();
    drive_p(1'b0, 24'h5A5A5A);
    chk("R2 invalid flag", 32'(p_ovld), 32'd0);
    chk("R2 invalid data passes", 32'(p_out), 32'(exp_drop(24'h5A5A5A)));
    drive_p(1'b1, 24'h5A5A5A);
    chk("R2 valid again", 32'(p_ovld), 32'd1);
  endtask

  task automatic t_depuncture();
    logic [14:0] vec [4] = '{15'h0000, 15'h7FFF, 15'h2AB3, 15'h1C71};
    for (int i = 0; i < 4; i++) begin
      drive_d(1'b1, vec[i]);
      chk("R5 depunct data", 32'(d_out), 32'(exp_fill(vec[i])));
      chk("R6 filler slots", 32'({d_out[20:18], d_out[11:9], d_out[2:0]}), 32'({FIL, FIL, FIL}));
    end
    drive_d(1'b0, 15'h3333);
    chk("R2 depunct invalid", 32'(d_ovld), 32'd0);
  endtask

  task automatic t_register_stream();
    logic [7:0] prev_d;
    logic       prev_v;
    prev_d = '0;
    prev_v = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c > 0) begin
        chk("R7 register data", 32'(r_out), 32'(prev_d));
        chk("R7 register valid", 32'(r_ovld), 32'(prev_v));
      end
      prev_d = 8'((c * 37 + 11) & 255);
      prev_v = c[0];
      r_in = prev_d;
      r_vld = prev_v;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_puncture();
    t_drop_ignored();
    t_invalid();
    t_depuncture();
    t_register_stream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule